// File: doc/BRIEF.md
# Performance Counter Bank

This block counts hardware events for software profiling. It holds a set of general counters, each of which is programmed to follow one event source, and one dedicated cycle counter. The event sources are input lanes that each carry a small delta per clock, a software increment written through the register port, and the clock itself. A counter adds its event's delta only when counting is enabled globally, enabled for that counter, and allowed by that counter's own permission input. The permission input stands in for any privilege or security filtering, which is done outside the block.

Each general counter wraps at 32 or 64 bits, as its type register selects. Overflow is found by comparing the delta with the headroom left before the add. An overflow sets a sticky status bit, and when the matching interrupt-enable bit is set it drives a level interrupt. Software can set or clear status bits directly, and the interrupt also follows the status word as it changes between zero and non-zero under those writes. The cycle counter can be slowed to one count per 64 enabled cycles. Two read-only capability words report which event IDs are implemented.

Top module: `pmu_bank`

## Requirements
- R1: After reset all counters, the overflow status, the count-enable and interrupt-enable words read 0, `irq` is low, and the control register reads only its fixed counter-count field: NUM_CTR in bits 15:11 (0x2000 for four counters).
- R2: A general counter adds its event's delta only in cycles where the control enable bit, its count-enable bit and its `countAllow` input are all 1. Otherwise it holds its value.
- R3: Headroom is (2^W−1) minus the value, with W = 64 when type bit 31 is 1 and W = 32 when it is 0. A 32-bit counter wraps inside bits 31:0 and keeps bits 63:32 unchanged. An overflow occurs exactly when the delta exceeds the headroom.
- R4: An overflow of general counter n sets bit n of the overflow status word, and an overflow of the cycle counter sets bit 31. Status bits stay set until cleared.
- R5: An overflow of counter n while bit n of the interrupt-enable word (address 0x02) is 1 drives `irq` high at the same clock edge that records the status bit.
- R6: Writing address 0x03 sets the status bits that are 1 in the data, and writing 0x04 clears them. Both read back at either address from the next cycle. Such a write that moves the status word from zero to non-zero raises `irq`, and one that moves it from non-zero to zero lowers `irq`.
- R7: In the control register (0x00), bit 0 is the global enable and bit 3 selects divide-by-64 for the cycle counter. Writing 1 to bit 1 clears every general counter but not the cycle counter. Writing 1 to bit 2 clears only the cycle counter and its prescaler. Bits 1 and 2 read 0, and the count field in bits 15:11 ignores writes.
- R8: A write to address 0x05 adds one to every enabled general counter whose bit is set in the written mask and whose event ID is the software-increment ID 0x0000.
- R9: The cycle counter (bit 31 of the enable and status words, value at address 0x5F) is always 64 bits wide. It adds one in each cycle where global enable and count-enable bit 31 are 1. In divide-by-64 mode it adds one only on every 64th such cycle.
- R10: A counter whose event ID is not implemented never counts.
- R11: For each implemented ID, the capability words at 0x06 and 0x07 set one bit. An ID in 0x00–0x1F sets bit ID of word 0x06, and an ID in 0x20–0x3F sets bit ID−0x20 of word 0x07. An ID in 0x4000–0x401F sets bit ID−0x4000+32 of word 0x06, and an ID in 0x4020–0x403F sets bit ID−0x4020+32 of word 0x07. The implemented IDs are 0x0000 (software increment), 0x0011 (cycles) and EVT_BASE+i for event lane i.
- R12: The type of counter n is at address 0x20+n: bits 15:0 hold the event ID, bit 31 selects 64-bit width, and the other bits read 0. The value of counter n is at 0x40+n and can be written. A read presents its data one cycle later with `regRdValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 7 | Register address |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, valid one cycle after `regRe` |
| regRdValid | output | 1 | Read data valid |
| evtDelta | input | NUM_EVT*DELTA_W | Per-lane event delta this cycle, lane i at bits i*DELTA_W upward |
| countAllow | input | NUM_CTR | Per-counter permission to count |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume that register reads and writes never target the same address in conflicting ways within one cycle. They also assume that the event deltas and permission inputs are stable across each clock edge. The stimulus meets both conditions: it drives every input only at the falling edge and issues at most one register access per cycle. The counter-hold and cycle-divider properties also assume that counter-value writes and reset strobes do not arrive in the cycles being checked. The bench schedules those writes only while the affected counter is disabled or idle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int ADDR_W  = 7;
  localparam int SLOTS   = 32;          // 31 general slots plus the cycle slot
  localparam int CYC_IDX = 31;
  localparam int DIV_W   = 6;           // cycle prescaler, 2**DIV_W cycles per tick

  // fixed register addresses
  localparam logic [ADDR_W-1:0] A_CTL   = 7'h00;
  localparam logic [ADDR_W-1:0] A_CEN   = 7'h01;
  localparam logic [ADDR_W-1:0] A_IEN   = 7'h02;
  localparam logic [ADDR_W-1:0] A_OSET  = 7'h03;
  localparam logic [ADDR_W-1:0] A_OCLR  = 7'h04;
  localparam logic [ADDR_W-1:0] A_SWINC = 7'h05;
  localparam logic [ADDR_W-1:0] A_CAP0  = 7'h06;
  localparam logic [ADDR_W-1:0] A_CAP1  = 7'h07;

  typedef struct packed {
    logic                globalEn;
    logic                div64;
    logic                evtReset;
    logic                cycReset;
    logic [SLOTS-1:0]    cntEn;
    logic [SLOTS-1:0]    valWe;
    logic [SLOTS-2:0]    typeWe;
    logic [SLOTS-2:0]    swInc;
    logic [63:0]         wdata;
  } pmuStrobes_t;

  typedef struct packed {
    logic        ovf;
    logic [63:0] val;
  } addRes_t;

  // headroom-based overflow check, then a wrap inside the selected width
  function automatic addRes_t addWrap(input logic [63:0] cur, input logic [63:0] delta,
                                      input logic wide);
    addRes_t r;
    logic [63:0] room;
    room  = wide ? ~cur : {32'h0, ~cur[31:0]};
    r.ovf = delta > room;
    r.val = wide ? cur + delta : {cur[63:32], cur[31:0] + delta[31:0]};
    return r;
  endfunction

  // capability bit for one implemented event id
  function automatic logic [63:0] capBit(input logic [15:0] id, input logic second);
    logic [15:0] lo;
    logic [15:0] hi;
    lo = second ? 16'h0020 : 16'h0000;
    hi = second ? 16'h4020 : 16'h4000;
    if (id >= lo && id < lo + 16'd32)
      capBit = 64'h1 << (id - lo);
    else if (id >= hi && id < hi + 16'd32)
      capBit = 64'h1 << (id - hi + 16'd32);
    else
      capBit = 64'h0;
  endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int          NUM_EVT  = 4,
  parameter int          DELTA_W  = 4,
  parameter logic [15:0] EVT_BASE = 16'h4000,
  parameter logic [15:0] SW_ID    = 16'h0000,
  parameter logic [15:0] CYC_ID   = 16'h0011
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       countOn,
  input  logic                       clear,
  input  logic                       swHit,
  input  logic [NUM_EVT*DELTA_W-1:0] evtDelta,
  input  logic                       typeWe,
  input  logic                       valWe,
  input  logic [63:0]                wdata,
  output logic [63:0]                val,
  output logic [31:0]                typeReg,
  output logic                       ovfHit
);

  logic [15:0] evId;
  logic [63:0] delta;
  logic        impl;
  logic        active;
  addRes_t     res;

  always_comb begin
    evId  = typeReg[15:0];
    delta = '0;
    impl  = 1'b0;
    if (evId == SW_ID) begin
      impl  = 1'b1;
      delta = 64'(swHit);
    end else if (evId == CYC_ID) begin
      impl  = 1'b1;
      delta = 64'd1;
    end
    for (int e = 0; e < NUM_EVT; e++) begin
      if (evId == EVT_BASE + 16'(e)) begin
        impl  = 1'b1;
        delta = 64'(evtDelta[e*DELTA_W +: DELTA_W]);
      end
    end
  end

  assign active = countOn & impl;
  assign res    = addWrap(val, delta, typeReg[31]);
  assign ovfHit = active & res.ovf & ~clear & ~valWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      val     <= '0;
      typeReg <= '0;
    end else begin
      if (clear)       val <= '0;
      else if (valWe)  val <= wdata;
      else if (active) val <= res.val;
      if (typeWe) typeReg <= {wdata[31], 15'h0, wdata[15:0]};
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (val == 64'h0)) else $error("clear did not zero counter"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!countOn && !clear && !valWe) |=> $stable(val)) else $error("idle counter moved"); // R2

  AST_UNIMPL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!impl && !clear && !valWe) |=> $stable(val)) else $error("unimplemented id counted"); // R10

endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int          NUM_CTR  = 4,
  parameter int          NUM_EVT  = 4,
  parameter int          DELTA_W  = 4,
  parameter logic [15:0] EVT_BASE = 16'h4000,
  parameter logic [15:0] SW_ID    = 16'h0000,
  parameter logic [15:0] CYC_ID   = 16'h0011
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pmuStrobes_t                stb,
  input  logic [NUM_EVT*DELTA_W-1:0] evtDelta,
  input  logic [NUM_CTR-1:0]         countAllow,
  output logic [SLOTS-1:0][63:0]     ctrVals,
  output logic [SLOTS-2:0][31:0]     ctrTypes,
  output logic [SLOTS-1:0]           ovfHits
);

  localparam logic [DIV_W-1:0] PRE_LAST = {DIV_W{1'b1}};

  for (genvar i = 0; i < SLOTS - 1; i++) begin : g_slot
    if (i < NUM_CTR) begin : g_ctr
      pmu_counter #(
        .NUM_EVT(NUM_EVT), .DELTA_W(DELTA_W), .EVT_BASE(EVT_BASE),
        .SW_ID(SW_ID), .CYC_ID(CYC_ID)
      ) u_ctr (
        .clk     (clk),
        .rstN    (rstN),
        .countOn (stb.globalEn & stb.cntEn[i] & countAllow[i]),
        .clear   (stb.evtReset),
        .swHit   (stb.swInc[i]),
        .evtDelta(evtDelta),
        .typeWe  (stb.typeWe[i]),
        .valWe   (stb.valWe[i]),
        .wdata   (stb.wdata),
        .val     (ctrVals[i]),
        .typeReg (ctrTypes[i]),
        .ovfHit  (ovfHits[i])
      );
    end else begin : g_none
      assign ctrVals[i]  = '0;
      assign ctrTypes[i] = '0;
      assign ovfHits[i]  = 1'b0;
    end
  end

  // dedicated cycle counter
  logic [63:0]      cycVal;
  logic [DIV_W-1:0] prescale;
  logic             cycOn;
  logic             tick;
  addRes_t          cycRes;

  assign cycOn  = stb.globalEn & stb.cntEn[CYC_IDX];
  assign tick   = cycOn & (!stb.div64 | (prescale == PRE_LAST));
  assign cycRes = addWrap(cycVal, 64'(tick), 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycVal   <= '0;
      prescale <= '0;
    end else if (stb.cycReset) begin
      cycVal   <= '0;
      prescale <= '0;
    end else begin
      if (stb.valWe[CYC_IDX]) cycVal <= stb.wdata;
      else if (tick)          cycVal <= cycRes.val;
      if (cycOn && stb.div64) prescale <= prescale + 1'b1;
    end
  end

  assign ctrVals[CYC_IDX] = cycVal;
  assign ovfHits[CYC_IDX] = tick & cycRes.ovf & ~stb.valWe[CYC_IDX];

  AST_CYC_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.div64 && prescale != PRE_LAST && !stb.cycReset && !stb.valWe[CYC_IDX])
      |=> $stable(cycVal)) else $error("cycle counter moved between divider ticks"); // R9

  AST_CYC_RESET: assert property (@(posedge clk) disable iff (!rstN)
    stb.cycReset |=> (cycVal == 64'h0 && prescale == '0)) else $error("cycle reset ignored"); // R7

endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int          NUM_CTR  = 4,
  parameter int          NUM_EVT  = 4,
  parameter logic [15:0] EVT_BASE = 16'h4000,
  parameter logic [15:0] SW_ID    = 16'h0000,
  parameter logic [15:0] CYC_ID   = 16'h0011
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic                   regRe,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [63:0]            regWdata,
  input  logic [SLOTS-1:0][63:0] ctrVals,
  input  logic [SLOTS-2:0][31:0] ctrTypes,
  input  logic [SLOTS-1:0]       ovfHits,
  output pmuStrobes_t            stb,
  output logic [63:0]            regRdata,
  output logic                   regRdValid,
  output logic                   irq
);

  localparam logic [SLOTS-1:0] IMPL_MASK =
    (SLOTS'((64'h1 << NUM_CTR) - 64'h1)) | (SLOTS'(1) << CYC_IDX);
  localparam logic [4:0] CNT_FIELD = 5'(NUM_CTR);

  logic             ctlEn;
  logic             ctlDiv;
  logic [SLOTS-1:0] cntEnReg;
  logic [SLOTS-1:0] intEnReg;
  logic [SLOTS-1:0] ovfStatus;
  logic [SLOTS-1:0] statusNext;
  logic             irqNext;
  logic             setWe;
  logic             clrWe;
  logic [SLOTS-1:0] wMask;
  logic [63:0]      cap0;
  logic [63:0]      cap1;
  logic [63:0]      rdMux;
  logic [4:0]       slotIdx;
  logic             typeSpace;
  logic             valSpace;

  assign wMask     = regWdata[SLOTS-1:0] & IMPL_MASK;
  assign setWe     = regWe && regAddr == A_OSET;
  assign clrWe     = regWe && regAddr == A_OCLR;
  assign slotIdx   = regAddr[4:0];
  assign typeSpace = regAddr[6:5] == 2'b01;
  assign valSpace  = regAddr[6:5] == 2'b10;

  // strobes to the datapath
  always_comb begin
    stb          = '0;
    stb.globalEn = ctlEn;
    stb.div64    = ctlDiv;
    stb.cntEn    = cntEnReg;
    stb.wdata    = regWdata;
    stb.evtReset = regWe && regAddr == A_CTL && regWdata[1];
    stb.cycReset = regWe && regAddr == A_CTL && regWdata[2];
    if (regWe && regAddr == A_SWINC) stb.swInc = wMask[SLOTS-2:0];
    for (int i = 0; i < SLOTS; i++) begin
      stb.valWe[i] = regWe && valSpace && slotIdx == 5'(i) && IMPL_MASK[i];
      if (i < SLOTS - 1)
        stb.typeWe[i] = regWe && typeSpace && slotIdx == 5'(i) && IMPL_MASK[i];
    end
  end

  // capability words from the implemented ids
  always_comb begin
    cap0 = capBit(SW_ID, 1'b0) | capBit(CYC_ID, 1'b0);
    cap1 = capBit(SW_ID, 1'b1) | capBit(CYC_ID, 1'b1);
    for (int e = 0; e < NUM_EVT; e++) begin
      cap0 |= capBit(EVT_BASE + 16'(e), 1'b0);
      cap1 |= capBit(EVT_BASE + 16'(e), 1'b1);
    end
  end

  // overflow status and interrupt level
  always_comb begin
    statusNext = ovfStatus;
    if (setWe) statusNext = statusNext | wMask;
    if (clrWe) statusNext = statusNext & ~wMask;
    statusNext = (statusNext | ovfHits) & IMPL_MASK;
    irqNext = irq;
    if (setWe || clrWe) begin
      if (ovfStatus == '0 && statusNext != '0)      irqNext = 1'b1;
      else if (ovfStatus != '0 && statusNext == '0) irqNext = 1'b0;
    end
    if ((ovfHits & intEnReg) != '0) irqNext = 1'b1;
  end

  always_comb begin
    rdMux = '0;
    case (regAddr)
      A_CTL:          rdMux = {48'h0, CNT_FIELD, 7'h0, ctlDiv, 2'b00, ctlEn};
      A_CEN:          rdMux = 64'(cntEnReg);
      A_IEN:          rdMux = 64'(intEnReg);
      A_OSET, A_OCLR: rdMux = 64'(ovfStatus);
      A_CAP0:         rdMux = cap0;
      A_CAP1:         rdMux = cap1;
      default: begin
        if (typeSpace && slotIdx != 5'(CYC_IDX)) rdMux = 64'(ctrTypes[slotIdx]);
        else if (valSpace)                       rdMux = ctrVals[slotIdx];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlEn      <= 1'b0;
      ctlDiv     <= 1'b0;
      cntEnReg   <= '0;
      intEnReg   <= '0;
      ovfStatus  <= '0;
      irq        <= 1'b0;
      regRdata   <= '0;
      regRdValid <= 1'b0;
    end else begin
      if (regWe && regAddr == A_CTL) begin
        ctlEn  <= regWdata[0];
        ctlDiv <= regWdata[3];
      end
      if (regWe && regAddr == A_CEN) cntEnReg <= wMask;
      if (regWe && regAddr == A_IEN) intEnReg <= wMask;
      ovfStatus  <= statusNext;
      irq        <= irqNext;
      regRdValid <= regRe;
      if (regRe) regRdata <= rdMux;
    end
  end

  AST_IRQ_ON_OVF: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfHits & intEnReg) != '0) |=> irq) else $error("enabled overflow without irq"); // R5

  AST_STATUS_RECORD: assert property (@(posedge clk) disable iff (!rstN)
    (ovfHits != '0) |=> ((ovfStatus & $past(ovfHits & IMPL_MASK)) == $past(ovfHits & IMPL_MASK)))
    else $error("overflow not recorded"); // R4

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && ovfStatus != '0 && (ovfStatus & ~wMask) == '0 && ovfHits == '0) |=> !irq)
    else $error("irq stayed after status cleared"); // R6

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> regRdValid) else $error("read without valid"); // R12

endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int          NUM_CTR  = 4,
  parameter int          NUM_EVT  = 4,
  parameter int          DELTA_W  = 4,
  parameter logic [15:0] EVT_BASE = 16'h4000,
  parameter logic [15:0] SW_ID    = 16'h0000,
  parameter logic [15:0] CYC_ID   = 16'h0011
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic                       regRe,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [63:0]                regWdata,
  output logic [63:0]                regRdata,
  output logic                       regRdValid,
  input  logic [NUM_EVT*DELTA_W-1:0] evtDelta,
  input  logic [NUM_CTR-1:0]         countAllow,
  output logic                       irq
);

  pmuStrobes_t            stb;
  logic [SLOTS-1:0][63:0] ctrVals;
  logic [SLOTS-2:0][31:0] ctrTypes;
  logic [SLOTS-1:0]       ovfHits;

  pmu_ctrl #(
    .NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .EVT_BASE(EVT_BASE),
    .SW_ID(SW_ID), .CYC_ID(CYC_ID)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .ctrVals(ctrVals), .ctrTypes(ctrTypes), .ovfHits(ovfHits),
    .stb(stb), .regRdata(regRdata), .regRdValid(regRdValid), .irq(irq)
  );

  pmu_datapath #(
    .NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT), .DELTA_W(DELTA_W), .EVT_BASE(EVT_BASE),
    .SW_ID(SW_ID), .CYC_ID(CYC_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evtDelta(evtDelta), .countAllow(countAllow),
    .ctrVals(ctrVals), .ctrTypes(ctrTypes), .ovfHits(ovfHits)
  );

endmodule

// File: tb/pmu_bank_test.sv
`timescale 1ns/1ps
module pmu_bank_test;

  localparam int NC = 4;
  localparam int NE = 4;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic          regRe = 1'b0;
  logic [6:0]    regAddr = '0;
  logic [63:0]   regWdata = '0;
  logic [63:0]   regRdata;
  logic          regRdValid;
  logic [NE*DW-1:0] evtDelta = '0;
  logic [NC-1:0] countAllow = '1;
  logic          irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [63:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  pmu_bank #(.NUM_CTR(NC), .NUM_EVT(NE), .DELTA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regRdValid(regRdValid),
    .evtDelta(evtDelta), .countAllow(countAllow), .irq(irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R12: unexpected read data actual=%h expected=none", regRdata);
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdata !== e) begin
          miscompares++;
          $display("FAIL %s: actual=%h expected=%h", t, regRdata, e);
        end
      end
    end
  end

  // all tasks are entered just after a falling edge
  task automatic regWrite(input logic [6:0] a, input logic [63:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readExpect(input logic [6:0] a, input logic [63:0] e, input string tag);
    regRe = 1'b1; regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic pulse(input int lane, input logic [DW-1:0] d, input int n);
    evtDelta[lane*DW +: DW] = d;
    repeat (n) @(negedge clk);
    evtDelta[lane*DW +: DW] = '0;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkIrq(1'b0, "R1");
    readExpect(7'h00, 64'h2000, "R1");
    readExpect(7'h03, 64'h0, "R1");
    readExpect(7'h01, 64'h0, "R1");
    readExpect(7'h40, 64'h0, "R1");

    // R11 capability words
    readExpect(7'h06, 64'h0000_000F_0002_0001, "R11");
    readExpect(7'h07, 64'h0, "R11");

    // R7 control masking
    regWrite(7'h00, 64'hFFFF);
    readExpect(7'h00, 64'h2009, "R7");
    regWrite(7'h00, 64'h1);
    readExpect(7'h00, 64'h2001, "R7");

    // R12 types: ctr0 lane0 32b, ctr1 lane1 64b, ctr2 sw, ctr3 unimplemented
    regWrite(7'h20, 64'h4000);
    regWrite(7'h21, 64'hFFFF_FFFF_8765_4001);
    regWrite(7'h22, 64'h0);
    regWrite(7'h23, 64'h1234);
    readExpect(7'h21, 64'h8000_4001, "R12");
    regWrite(7'h01, 64'hF);

    // R2 counting
    pulse(0, 4'd3, 2);
    pulse(1, 4'd5, 1);
    readExpect(7'h40, 64'd6, "R2");
    readExpect(7'h41, 64'd5, "R2");
    readExpect(7'h43, 64'd0, "R10");
    readExpect(7'h42, 64'd0, "R8");

    // R2 gating by allow, per-counter enable, global enable
    countAllow[0] = 1'b0;
    pulse(0, 4'd3, 1);
    countAllow[0] = 1'b1;
    readExpect(7'h40, 64'd6, "R2");
    regWrite(7'h01, 64'hE);
    pulse(0, 4'd3, 1);
    regWrite(7'h01, 64'hF);
    readExpect(7'h40, 64'd6, "R2");
    regWrite(7'h00, 64'h0);
    pulse(0, 4'd3, 1);
    regWrite(7'h00, 64'h1);
    readExpect(7'h40, 64'd6, "R2");

    // R8 software increment
    regWrite(7'h05, 64'h7);
    readExpect(7'h42, 64'd1, "R8");
    readExpect(7'h40, 64'd6, "R8");
    regWrite(7'h05, 64'h3);
    readExpect(7'h42, 64'd1, "R8");

    // R3 R4 32-bit wrap keeps upper half
    regWrite(7'h40, 64'h1_FFFF_FFFE);
    pulse(0, 4'd5, 1);
    readExpect(7'h40, 64'h1_0000_0003, "R3");
    readExpect(7'h03, 64'h1, "R4");
    checkIrq(1'b0, "R5");

    // R6 status set/clear and irq transitions
    regWrite(7'h04, 64'h1);
    readExpect(7'h03, 64'h0, "R6");
    checkIrq(1'b0, "R6");
    regWrite(7'h03, 64'h4);
    checkIrq(1'b1, "R6");
    readExpect(7'h04, 64'h4, "R6");
    regWrite(7'h04, 64'h4);
    checkIrq(1'b0, "R6");

    // R3 64-bit: no overflow across bit 32
    regWrite(7'h41, 64'hFFFF_FFFF);
    pulse(1, 4'd1, 1);
    readExpect(7'h41, 64'h1_0000_0000, "R3");
    readExpect(7'h03, 64'h0, "R3");

    // R5 enabled overflow on 64-bit counter
    regWrite(7'h02, 64'h2);
    regWrite(7'h41, 64'hFFFF_FFFF_FFFF_FFFD);
    pulse(1, 4'd3, 1);
    checkIrq(1'b1, "R5");
    readExpect(7'h41, 64'h0, "R3");
    readExpect(7'h03, 64'h2, "R4");
    regWrite(7'h04, 64'h2);
    checkIrq(1'b0, "R6");

    // R9 cycle counter: 11 enabled edges
    regWrite(7'h01, 64'h8000_000F);
    repeat (10) @(negedge clk);
    regWrite(7'h01, 64'hF);
    readExpect(7'h5F, 64'd11, "R9");

    // R9 divide-by-64 after cycle reset: 131 enabled edges give 2
    regWrite(7'h00, 64'hD);
    readExpect(7'h5F, 64'd0, "R7");
    readExpect(7'h42, 64'd1, "R7");
    regWrite(7'h01, 64'h8000_000F);
    repeat (130) @(negedge clk);
    regWrite(7'h01, 64'hF);
    readExpect(7'h5F, 64'd2, "R9");

    // R7 event reset spares the cycle counter
    regWrite(7'h00, 64'h3);
    readExpect(7'h40, 64'd0, "R7");
    readExpect(7'h42, 64'd0, "R7");
    readExpect(7'h5F, 64'd2, "R7");

    // R9 R4 R5 cycle counter overflow
    regWrite(7'h5F, 64'hFFFF_FFFF_FFFF_FFFF);
    regWrite(7'h02, 64'h8000_0002);
    regWrite(7'h01, 64'h8000_000F);
    regWrite(7'h01, 64'hF);
    checkIrq(1'b1, "R5");
    readExpect(7'h5F, 64'd0, "R9");
    readExpect(7'h03, 64'h8000_0000, "R4");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R12: actual=%0d reads pending expected=0", expQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule